// File: doc/BRIEF.md
# Banked Bit-Addressable Scratchpad

This block is the 256-location internal byte store of a small 8-bit controller core. One array of flops is reachable three ways: as plain bytes, as single bits that alias onto a fixed band of bytes, and as eight working registers. The working registers sit in one of four banks, picked by a small bank register. The core's execution logic drives a byte port and a bit port. Every access that resolves to the special-register space is forwarded, on the same cycle, over a simple request interface to logic outside the block.

On the byte port, a two-bit mode chooses how the address is read. Mode 0 is direct: the address is used as given. Mode 1 is register: the low three bits name a working register in the current bank. Mode 2 is pointer: bit 0 picks working register 0 or 1 of the current bank, and that register's contents become the address. Mode 3 is indirect: the address is given, but it is treated as a pointer result. Direct addresses in the upper half reach the special registers. Indirect addresses in the upper half reach a separate 128-byte RAM instead. On the bit port, a set or clear is a single-cycle read-modify-write of the containing byte, whether that byte is in RAM or in a special register.

Top module: `bitbank_store`

## Requirements
- R1: In register mode (byte_mode = 1), index n = byte_addr[2:0] addresses lower-RAM byte bank*8 + n, where bank is the current bank register.
- R2: The bank register is 0 after reset. It takes bank_in in the cycle that bank_ld is high, and holds its value otherwise.
- R3: In direct mode (byte_mode = 0), an address below 80h reaches lower RAM. An address at 80h or above leaves RAM untouched and drives sfr_en high in the same cycle, with sfr_addr equal to the address, sfr_we equal to byte_we, and sfr_wdata equal to byte_wdata.
- R4: In indirect mode (byte_mode = 3), an address at 80h or above reads or writes the upper 128-byte RAM, and sfr_en stays low. An address below 80h reaches lower RAM.
- R5: In pointer mode (byte_mode = 2), byte_addr[0] selects working register 0 or 1 of the current bank. Its contents are then routed as in R4.
- R6: A bit address b below 80h names bit b[2:0] of lower-RAM byte 20h + b[6:3]. Byte writes and bit operations on that band always agree.
- R7: A bit address b at 80h or above names bit b[2:0] of the special register at b with its low three bits cleared. A set or clear drives sfr_en and sfr_we, with sfr_wdata equal to sfr_rdata with that one bit changed. A bit read drives sfr_en with sfr_we low.
- R8: bit_op 3 sets the addressed bit and bit_op 2 clears it. bit_op 1 reads it and bit_op 0 does nothing. A set or clear leaves the other seven bits of the byte unchanged.
- R9: A byte read (byte_en high, byte_we low) returns its data on byte_rdata one cycle later, with byte_rvalid high for that cycle. A bit read returns its data on bit_rdata one cycle later, with bit_rvalid high. After reset both valids are low and both data outputs are 0.
- R10: When byte_en and a bit operation are requested in the same cycle, the byte access is carried out. The bit operation is dropped: it changes no storage and raises no bit_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_ld | input | 1 | Load the bank register from bank_in |
| bank_in | input | 2 | New working-register bank |
| byte_en | input | 1 | Byte port request |
| byte_mode | input | 2 | 0 direct, 1 register, 2 pointer, 3 indirect |
| byte_we | input | 1 | Byte port write (1) or read (0) |
| byte_addr | input | 8 | Byte address, register index or pointer select |
| byte_wdata | input | 8 | Byte write data |
| byte_rvalid | output | 1 | Byte read data valid |
| byte_rdata | output | 8 | Byte read data |
| bit_op | input | 2 | 0 none, 1 read, 2 clear, 3 set |
| bit_addr | input | 8 | Bit address |
| bit_rvalid | output | 1 | Bit read data valid |
| bit_rdata | output | 1 | Bit read data |
| sfr_en | output | 1 | Special-register request |
| sfr_we | output | 1 | Special-register write |
| sfr_addr | output | 8 | Special-register byte address |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, combinational from the addressed register |

## Verification
The assertions check four things on every cycle. A special-register request always carries an upper-half address and is never raised by an indirect or pointer access. A bit-driven request is aligned to a multiple of 8 and changes at most one bit of the value returned. Read valids appear only after a matching request, and the bank register holds unless it is loaded. Some behaviour only the bench scenarios can show, by comparing every access against a model array. That covers the bank arithmetic, pointer fetches through working registers 0 and 1, and the aliasing between bit numbers and bytes in the 20h band. It also covers the dropping of a bit operation that collides with a byte request.

// File: rtl/bbs_pkg.sv
`timescale 1ns/1ps
package bbs_pkg;

   typedef enum logic [1:0] {
      AM_DIRECT = 2'd0,
      AM_REG    = 2'd1,
      AM_PTR    = 2'd2,
      AM_INDIR  = 2'd3
   } acc_mode_e;

   typedef enum logic [1:0] {
      BOP_NONE = 2'd0,
      BOP_READ = 2'd1,
      BOP_CLR  = 2'd2,
      BOP_SET  = 2'd3
   } bit_op_e;

   typedef enum logic [1:0] {
      TGT_LOW  = 2'd0,
      TGT_HIGH = 2'd1,
      TGT_SFR  = 2'd2
   } tgt_e;

endpackage

// File: rtl/bbs_route.sv
`timescale 1ns/1ps
module bbs_route
   import bbs_pkg::*;
#(
   parameter int AW    = 8,
   parameter int NREG  = 8,
   parameter int NBANK = 4,
   localparam int IDX_W  = $clog2(NREG),
   localparam int BANK_W = $clog2(NBANK)
) (
   input  logic [1:0]        mode,
   input  logic [AW-1:0]     addr,
   input  logic [BANK_W-1:0] bank,
   input  logic [AW-1:0]     ptr_val,
   output logic [AW-2:0]     ptr_idx,
   output tgt_e              tgt,
   output logic [AW-1:0]     eff
);

   logic [AW-1:0] reg_addr;

   // working register n of bank b sits at b*NREG + n
   assign reg_addr = AW'({bank, addr[IDX_W-1:0]});
   // pointer registers are the first two of the bank
   assign ptr_idx  = (AW-1)'({bank, {(IDX_W-1){1'b0}}, addr[0]});

   always_comb begin
      case (acc_mode_e'(mode))
         AM_DIRECT: begin
            eff = addr;
            tgt = addr[AW-1] ? TGT_SFR : TGT_LOW;
         end
         AM_REG: begin
            eff = reg_addr;
            tgt = TGT_LOW;
         end
         AM_PTR: begin
            eff = ptr_val;
            tgt = ptr_val[AW-1] ? TGT_HIGH : TGT_LOW;
         end
         default: begin
            eff = addr;
            tgt = addr[AW-1] ? TGT_HIGH : TGT_LOW;
         end
      endcase
   end

endmodule

// File: rtl/bbs_bitmap.sv
`timescale 1ns/1ps
module bbs_bitmap
   import bbs_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int BIT_BASE = 32,
   localparam int POS_W   = $clog2(DW)
) (
   input  logic [AW-1:0]    baddr,
   output tgt_e             tgt,
   output logic [AW-1:0]    byte_addr,
   output logic [POS_W-1:0] pos
);

   assign pos = baddr[POS_W-1:0];

   always_comb begin
      if (baddr[AW-1]) begin
         tgt       = TGT_SFR;
         byte_addr = {baddr[AW-1:POS_W], {POS_W{1'b0}}};
      end else begin
         tgt       = TGT_LOW;
         byte_addr = AW'(BIT_BASE) + AW'(baddr[AW-2:POS_W]);
      end
   end

endmodule

// File: rtl/bbs_store.sv
`timescale 1ns/1ps
module bbs_store #(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter bit UPPER_RAM = 1'b1,
   localparam int IW       = AW - 1,
   localparam int HALF     = 1 << IW
) (
   input  logic          clk,
   input  logic          lo_we,
   input  logic [IW-1:0] lo_waddr,
   input  logic          hi_we,
   input  logic [IW-1:0] hi_waddr,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] lo_ptr_addr,
   output logic [DW-1:0] lo_ptr_q,
   input  logic [IW-1:0] lo_rd_addr,
   output logic [DW-1:0] lo_rd_q,
   input  logic [IW-1:0] hi_rd_addr,
   output logic [DW-1:0] hi_rd_q
);

   logic [DW-1:0] lo_mem [HALF];

   always_ff @(posedge clk) begin
      if (lo_we) lo_mem[lo_waddr] <= wdata;
   end

   assign lo_ptr_q = lo_mem[lo_ptr_addr];
   assign lo_rd_q  = lo_mem[lo_rd_addr];

   generate
      if (UPPER_RAM) begin : g_upper
         logic [DW-1:0] hi_mem [HALF];
         always_ff @(posedge clk) begin
            if (hi_we) hi_mem[hi_waddr] <= wdata;
         end
         assign hi_rd_q = hi_mem[hi_rd_addr];
      end else begin : g_no_upper
         assign hi_rd_q = '0;
      end
   endgenerate

endmodule

// File: rtl/bitbank_store.sv
`timescale 1ns/1ps
module bitbank_store
   import bbs_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter int NREG      = 8,
   parameter int NBANK     = 4,
   parameter int BIT_BASE  = 32,
   parameter bit UPPER_RAM = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bank_ld,
   input  logic [$clog2(NBANK)-1:0] bank_in,
   input  logic                     byte_en,
   input  logic [1:0]               byte_mode,
   input  logic                     byte_we,
   input  logic [AW-1:0]            byte_addr,
   input  logic [DW-1:0]            byte_wdata,
   output logic                     byte_rvalid,
   output logic [DW-1:0]            byte_rdata,
   input  logic [1:0]               bit_op,
   input  logic [AW-1:0]            bit_addr,
   output logic                     bit_rvalid,
   output logic                     bit_rdata,
   output logic                     sfr_en,
   output logic                     sfr_we,
   output logic [AW-1:0]            sfr_addr,
   output logic [DW-1:0]            sfr_wdata,
   input  logic [DW-1:0]            sfr_rdata
);

   localparam int BANK_W = $clog2(NBANK);
   localparam int POS_W  = $clog2(DW);
   localparam int IW     = AW - 1;
   localparam int HALF   = 1 << IW;

   // elaboration-time parameter checks
   if (DW != (1 << POS_W)) begin : g_bad_dw
      $error("DW must be a power of two");
   end
   if (NREG < 4 || NREG != (1 << $clog2(NREG))) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 4");
   end
   if (NREG * NBANK > BIT_BASE) begin : g_bad_banks
      $error("register banks overlap the bit band");
   end
   if (BIT_BASE + HALF / DW > HALF) begin : g_bad_band
      $error("bit band does not fit in the lower half");
   end

   logic [BANK_W-1:0] bank_q;
   logic              byte_act, bit_act, bit_wr;
   bit_op_e           bop;
   tgt_e              r_tgt, b_tgt;
   logic [AW-1:0]     r_eff, b_byte;
   logic [POS_W-1:0]  b_pos;
   logic [AW-2:0]     ptr_idx;
   logic [DW-1:0]     ptr_q, lo_q, hi_q;
   logic [DW-1:0]     bit_cur, bit_mod;
   logic              lo_we, hi_we;
   logic [IW-1:0]     lo_waddr, lo_raddr;
   logic [DW-1:0]     st_wdata;

   assign bop      = bit_op_e'(bit_op);
   assign byte_act = byte_en;
   assign bit_act  = (bop != BOP_NONE) && !byte_en;
   assign bit_wr   = bit_act && (bop == BOP_SET || bop == BOP_CLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q <= '0;
      else if (bank_ld) bank_q <= bank_in;
   end

   bbs_route #(.AW(AW), .NREG(NREG), .NBANK(NBANK)) u_route (
      .mode    (byte_mode),
      .addr    (byte_addr),
      .bank    (bank_q),
      .ptr_val (ptr_q),
      .ptr_idx (ptr_idx),
      .tgt     (r_tgt),
      .eff     (r_eff)
   );

   bbs_bitmap #(.AW(AW), .DW(DW), .BIT_BASE(BIT_BASE)) u_bitmap (
      .baddr     (bit_addr),
      .tgt       (b_tgt),
      .byte_addr (b_byte),
      .pos       (b_pos)
   );

   assign lo_raddr = byte_act ? r_eff[IW-1:0] : b_byte[IW-1:0];

   bbs_store #(.AW(AW), .DW(DW), .UPPER_RAM(UPPER_RAM)) u_store (
      .clk         (clk),
      .lo_we       (lo_we),
      .lo_waddr    (lo_waddr),
      .hi_we       (hi_we),
      .hi_waddr    (r_eff[IW-1:0]),
      .wdata       (st_wdata),
      .lo_ptr_addr (ptr_idx),
      .lo_ptr_q    (ptr_q),
      .lo_rd_addr  (lo_raddr),
      .lo_rd_q     (lo_q),
      .hi_rd_addr  (r_eff[IW-1:0]),
      .hi_rd_q     (hi_q)
   );

   // bit read-modify-write on whichever byte holds the bit
   assign bit_cur = (b_tgt == TGT_SFR) ? sfr_rdata : lo_q;
   always_comb begin
      bit_mod        = bit_cur;
      bit_mod[b_pos] = (bop == BOP_SET);
   end

   always_comb begin
      lo_we    = 1'b0;
      hi_we    = 1'b0;
      lo_waddr = lo_raddr;
      st_wdata = byte_wdata;
      if (byte_act) begin
         lo_we = byte_we && (r_tgt == TGT_LOW);
         hi_we = byte_we && (r_tgt == TGT_HIGH);
      end else begin
         lo_we    = bit_wr && (b_tgt == TGT_LOW);
         st_wdata = bit_mod;
      end
   end

   always_comb begin
      if (byte_act) begin
         sfr_en    = (r_tgt == TGT_SFR);
         sfr_we    = (r_tgt == TGT_SFR) && byte_we;
         sfr_addr  = r_eff;
         sfr_wdata = byte_wdata;
      end else begin
         sfr_en    = bit_act && (b_tgt == TGT_SFR);
         sfr_we    = bit_wr && (b_tgt == TGT_SFR);
         sfr_addr  = b_byte;
         sfr_wdata = bit_mod;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_rvalid <= 1'b0;
         byte_rdata  <= '0;
         bit_rvalid  <= 1'b0;
         bit_rdata   <= 1'b0;
      end else begin
         byte_rvalid <= byte_act && !byte_we;
         bit_rvalid  <= bit_act && (bop == BOP_READ);
         if (byte_act && !byte_we) begin
            case (r_tgt)
               TGT_SFR:  byte_rdata <= sfr_rdata;
               TGT_HIGH: byte_rdata <= hi_q;
               default:  byte_rdata <= lo_q;
            endcase
         end
         if (bit_act && (bop == BOP_READ)) bit_rdata <= bit_cur[b_pos];
      end
   end

endmodule

// File: rtl/bbs_checks.sv
`timescale 1ns/1ps
module bbs_checks #(
   parameter int AW     = 8,
   parameter int DW     = 8,
   parameter int BANK_W = 2,
   localparam int POS_W = $clog2(DW)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bank_ld,
   input logic [BANK_W-1:0] bank_q,
   input logic              byte_en,
   input logic [1:0]        byte_mode,
   input logic              byte_we,
   input logic [1:0]        bit_op,
   input logic              byte_rvalid,
   input logic              bit_rvalid,
   input logic              sfr_en,
   input logic              sfr_we,
   input logic [AW-1:0]     sfr_addr,
   input logic [DW-1:0]     sfr_wdata,
   input logic [DW-1:0]     sfr_rdata
);

   AST_SFR_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_en |-> sfr_addr[AW-1]); // R3

   AST_SFR_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_we |-> sfr_en); // R3

   AST_INDIRECT_NO_SFR: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_en && byte_mode[1]) |-> !sfr_en); // R4

   AST_BIT_SFR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_en && !byte_en) |-> (sfr_addr[POS_W-1:0] == '0)); // R7

   AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_we && !byte_en) |-> ($countones(sfr_wdata ^ sfr_rdata) <= 1)); // R8

   AST_BYTE_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rvalid |-> $past(byte_en && !byte_we)); // R9

   AST_BIT_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      bit_rvalid |-> $past(bit_op == 2'd1 && !byte_en)); // R10

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_ld |=> $stable(bank_q)); // R2

endmodule

bind bitbank_store bbs_checks #(.AW(AW), .DW(DW), .BANK_W($clog2(NBANK))) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bank_ld     (bank_ld),
   .bank_q      (bank_q),
   .byte_en     (byte_en),
   .byte_mode   (byte_mode),
   .byte_we     (byte_we),
   .bit_op      (bit_op),
   .byte_rvalid (byte_rvalid),
   .bit_rvalid  (bit_rvalid),
   .sfr_en      (sfr_en),
   .sfr_we      (sfr_we),
   .sfr_addr    (sfr_addr),
   .sfr_wdata   (sfr_wdata),
   .sfr_rdata   (sfr_rdata)
);

// File: tb/sim_bitbank_store.sv
`timescale 1ns/1ps
module sim_bitbank_store;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bank_ld;
   logic [1:0] bank_in;
   logic       byte_en;
   logic [1:0] byte_mode;
   logic       byte_we;
   logic [7:0] byte_addr;
   logic [7:0] byte_wdata;
   logic       byte_rvalid;
   logic [7:0] byte_rdata;
   logic [1:0] bit_op;
   logic [7:0] bit_addr;
   logic       bit_rvalid;
   logic       bit_rdata;
   logic       sfr_en;
   logic       sfr_we;
   logic [7:0] sfr_addr;
   logic [7:0] sfr_wdata;
   logic [7:0] sfr_rdata;

   int vectors = 0;
   int miscmp  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   bitbank_store u0 (
      .clk(clk), .rst_n(rst_n), .bank_ld(bank_ld), .bank_in(bank_in),
      .byte_en(byte_en), .byte_mode(byte_mode), .byte_we(byte_we),
      .byte_addr(byte_addr), .byte_wdata(byte_wdata),
      .byte_rvalid(byte_rvalid), .byte_rdata(byte_rdata),
      .bit_op(bit_op), .bit_addr(bit_addr),
      .bit_rvalid(bit_rvalid), .bit_rdata(bit_rdata),
      .sfr_en(sfr_en), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
   );

   // special-register responder standing in for the outside logic
   logic [7:0] env_sfr [0:127];
   assign sfr_rdata = env_sfr[sfr_addr[6:0]];
   always @(posedge clk) begin
      if (sfr_en && sfr_we) env_sfr[sfr_addr[6:0]] <= sfr_wdata;
   end

   // behavioural model
   logic [7:0] exp_lo  [0:127];
   logic [7:0] exp_hi  [0:127];
   logic [7:0] exp_sfr [0:127];
   logic [1:0] exp_bank;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
         $finish;
      end
   endtask

   // target: 0 lower RAM, 1 upper RAM, 2 special register
   task automatic byte_acc(input logic [1:0] m, input logic [7:0] a, input logic w,
                           input logic [7:0] wd, input string tag);
      logic [7:0] ea;
      int         tg;
      logic [7:0] ev;
      case (m)
         2'd0: begin ea = a; tg = a[7] ? 2 : 0; end
         2'd1: begin ea = 8'({exp_bank, a[2:0]}); tg = 0; end
         2'd2: begin ea = exp_lo[7'({exp_bank, 2'b00, a[0]})]; tg = ea[7] ? 1 : 0; end
         default: begin ea = a; tg = a[7] ? 1 : 0; end
      endcase
      ev = (tg == 0) ? exp_lo[ea[6:0]] : (tg == 1) ? exp_hi[ea[6:0]] : exp_sfr[ea[6:0]];
      @(negedge clk);
      byte_en = 1'b1; byte_mode = m; byte_addr = a; byte_we = w; byte_wdata = wd;
      bit_op = 2'd0;
      #1;
      chk({tag, " R3 sfr_en"}, 32'(sfr_en), 32'(tg == 2));
      if (tg == 2) begin
         chk("R3 sfr_addr", 32'(sfr_addr), 32'(ea));
         chk("R3 sfr_we", 32'(sfr_we), 32'(w));
         if (w) chk("R3 sfr_wdata", 32'(sfr_wdata), 32'(wd));
      end
      @(negedge clk);
      byte_en = 1'b0; byte_we = 1'b0;
      chk("R9 byte_rvalid", 32'(byte_rvalid), 32'(!w));
      if (!w) chk(tag, 32'(byte_rdata), 32'(ev));
      if (w) begin
         if (tg == 0)      exp_lo[ea[6:0]]  = wd;
         else if (tg == 1) exp_hi[ea[6:0]]  = wd;
         else              exp_sfr[ea[6:0]] = wd;
      end
   endtask

   task automatic bit_acc(input logic [1:0] op, input logic [7:0] b, input string tag);
      logic       hi;
      logic [6:0] idx;
      logic [7:0] old, nw;
      hi  = b[7];
      idx = hi ? {b[6:3], 3'b000} : 7'(32 + b[6:3]);
      old = hi ? exp_sfr[idx] : exp_lo[idx];
      nw  = old;
      if (op == 2'd3) nw[b[2:0]] = 1'b1;
      if (op == 2'd2) nw[b[2:0]] = 1'b0;
      @(negedge clk);
      byte_en = 1'b0; bit_op = op; bit_addr = b;
      #1;
      chk("R7 sfr_en bit", 32'(sfr_en), 32'(hi && op != 2'd0));
      if (hi && op != 2'd0) begin
         chk("R7 sfr_addr bit", 32'(sfr_addr), 32'({1'b1, idx}));
         chk("R7 sfr_we bit", 32'(sfr_we), 32'(op != 2'd1));
         if (op != 2'd1) chk("R8 sfr_wdata one bit", 32'(sfr_wdata), 32'(nw));
      end
      @(negedge clk);
      bit_op = 2'd0;
      chk("R9 bit_rvalid", 32'(bit_rvalid), 32'(op == 2'd1));
      if (op == 2'd1) chk(tag, 32'(bit_rdata), 32'(old[b[2:0]]));
      if (hi) exp_sfr[idx] = nw;
      else    exp_lo[idx]  = nw;
   endtask

   // byte read of a lower address colliding with a bit set
   task automatic clash(input logic [7:0] a, input logic [7:0] b);
      @(negedge clk);
      byte_en = 1'b1; byte_mode = 2'd0; byte_addr = {1'b0, a[6:0]}; byte_we = 1'b0;
      bit_op = 2'd3; bit_addr = b;
      @(negedge clk);
      byte_en = 1'b0; bit_op = 2'd0;
      chk("R10 byte wins rvalid", 32'(byte_rvalid), 32'd1);
      chk("R10 byte wins data", 32'(byte_rdata), 32'(exp_lo[a[6:0]]));
      chk("R10 bit dropped", 32'(bit_rvalid), 32'd0);
   endtask

   task automatic load_bank(input logic [1:0] v);
      @(negedge clk);
      bank_ld = 1'b1; bank_in = v;
      @(negedge clk);
      bank_ld = 1'b0;
      exp_bank = v;
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin
         env_sfr[i] = 8'(i) ^ 8'h5A;
         exp_sfr[i] = 8'(i) ^ 8'h5A;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED);
      rst_n = 1'b0; bank_ld = 1'b0; bank_in = 2'd0; byte_en = 1'b0;
      byte_mode = 2'd0; byte_we = 1'b0; byte_addr = '0; byte_wdata = '0;
      bit_op = 2'd0; bit_addr = '0; exp_bank = 2'd0;
      repeat (3) @(negedge clk);
      chk("R9 reset byte_rvalid", 32'(byte_rvalid), 32'd0);
      chk("R9 reset bit_rvalid", 32'(bit_rvalid), 32'd0);
      chk("R9 reset byte_rdata", 32'(byte_rdata), 32'd0);
      rst_n = 1'b1;

      // fill both RAM halves
      for (int i = 0; i < 128; i++) byte_acc(2'd0, 8'(i), 1'b1, 8'(i * 7 + 3), "R3 fill");
      for (int i = 128; i < 256; i++) byte_acc(2'd3, 8'(i), 1'b1, 8'(i * 5 + 1), "R4 fill");

      // R2: bank 0 after reset, register 3 is byte 03h
      byte_acc(2'd1, 8'h03, 1'b0, 8'h00, "R2 default bank");
      // R1: bank 2 register 6 is byte 16h
      load_bank(2'd2);
      byte_acc(2'd1, 8'h06, 1'b1, 8'hC3, "R1 reg write");
      byte_acc(2'd0, 8'h16, 1'b0, 8'h00, "R1 reg alias");
      // R5: bank 1 pointers
      load_bank(2'd1);
      byte_acc(2'd0, 8'h08, 1'b1, 8'h9A, "R5 set ptr0");
      byte_acc(2'd0, 8'h09, 1'b1, 8'h45, "R5 set ptr1");
      byte_acc(2'd2, 8'h00, 1'b0, 8'h00, "R5 ptr0 upper");
      byte_acc(2'd2, 8'h01, 1'b0, 8'h00, "R5 ptr1 lower");
      // R4 versus R3: same upper address, two destinations
      byte_acc(2'd3, 8'hE0, 1'b1, 8'h11, "R4 upper write");
      byte_acc(2'd0, 8'hE0, 1'b1, 8'h22, "R3 sfr write");
      byte_acc(2'd3, 8'hE0, 1'b0, 8'h00, "R4 upper read");
      byte_acc(2'd0, 8'hE0, 1'b0, 8'h00, "R3 sfr read");
      // R6: byte 20h seen as bits 00h..07h
      byte_acc(2'd0, 8'h20, 1'b1, 8'hA5, "R6 band write");
      for (int i = 0; i < 8; i++) bit_acc(2'd1, 8'(i), "R6 band bit");
      bit_acc(2'd3, 8'h25, "R6 set 25h");
      byte_acc(2'd0, 8'h24, 1'b0, 8'h00, "R6 byte 24h");
      // R8: one bit only
      byte_acc(2'd0, 8'h2C, 1'b1, 8'h00, "R8 clear byte");
      bit_acc(2'd3, 8'h63, "R8 set");
      byte_acc(2'd0, 8'h2C, 1'b0, 8'h00, "R8 only bit 3");
      byte_acc(2'd0, 8'h2F, 1'b1, 8'hFF, "R8 fill byte");
      bit_acc(2'd2, 8'h7F, "R8 clear");
      byte_acc(2'd0, 8'h2F, 1'b0, 8'h00, "R8 only bit 7");
      // R7: bit 87h is bit 7 of register 80h
      bit_acc(2'd3, 8'h87, "R7 set 87h");
      byte_acc(2'd0, 8'h80, 1'b0, 8'h00, "R7 reg 80h");
      bit_acc(2'd1, 8'hF2, "R7 read F2h");
      // R10: collision, then confirm the bit was not set
      bit_acc(2'd2, 8'h41, "R10 prep");
      clash(8'h30, 8'h41);
      bit_acc(2'd1, 8'h41, "R10 bit unchanged");

      // constrained random mix
      for (int n = 0; n < 3000; n++) begin
         int unsigned k;
         logic [1:0]  m;
         logic [7:0]  a;
         k = $urandom % 10;
         m = 2'($urandom);
         a = 8'($urandom);
         case (k)
            0, 1, 2: begin
               case (m)
                  2'd0: byte_acc(m, a, 1'b0, 8'h00, "R3 direct read");
                  2'd1: byte_acc(m, a, 1'b0, 8'h00, "R1 reg read");
                  2'd2: byte_acc(m, a, 1'b0, 8'h00, "R5 ptr read");
                  default: byte_acc(m, a, 1'b0, 8'h00, "R4 indirect read");
               endcase
            end
            3, 4: byte_acc(m, a, 1'b1, 8'($urandom), "R3 random write");
            5, 6: bit_acc(2'd1, a, a[7] ? "R7 sfr bit read" : "R6 bit read");
            7: bit_acc(($urandom % 2) ? 2'd3 : 2'd2, a, "R8 random rmw");
            8: load_bank(m);
            default: clash(a, {1'b0, a[6:0]});
         endcase
      end
      finish_run();
   end

   initial begin
      #1_500_000;
      miscmp++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

endmodule